// File: doc/BRIEF.md
# CPU Control Frame Mailbox

This block is a register-mapped mailbox through which a host CPU and a switch core pass control frames. It holds one receive buffer, filled by the CPU and read by the switch, and two transmit buffers, filled by the switch and drained by the CPU. The CPU moves frame bytes one at a time through a single data port register, each access stepping an internal byte pointer. Ownership of a buffer changes hands through self-clearing command bits, and a status register shows the CPU which buffers it may use.

Each frame begins with an 8-byte header (size, source port, VLAN tag) followed by a payload whose length is a multiple of 8 bytes. The mailbox stores these bytes verbatim and leaves their meaning to software and to the switch. On the switch side, the receive buffer is read by address and handed back with a done pulse. Each transmit buffer is loaded through a write-enable, address and data port, and a load-done pulse marks it ready for the CPU. The CPU drains the transmit buffers strictly in alternation, starting with transmit buffer 1.

Top module: `ctrlFrameMailbox`

## Requirements
- R1: After reset the status register (address 4) reads 0x01: the receive buffer is free and both transmit buffers are empty. The data port (address 3) reads 0.
- R2: While the CPU owns the receive buffer, a write to address 3 stores the byte at the write pointer and advances the pointer by one. The switch reads byte n at `swRxAddr` = n.
- R3: A write to address 4 with bit 0 set, while the CPU owns the receive buffer, passes the buffer to the switch. On the next cycle `swRxReady` is 1 and status bit 0 is 0. A `swRxDone` pulse returns the buffer to the CPU. The write pointer restarts at 0 on every change of owner.
- R4: Data port writes made while the switch owns the receive buffer are ignored and leave the stored bytes unchanged.
- R5: `swTxSel` = 0 selects transmit buffer 1 (status bit 1, command bit 1), and `swTxSel` = 1 selects transmit buffer 2 (status bit 2, command bit 2). A `swTxLoadDone` pulse on a free buffer marks it ready from the next cycle, and `swTxFree` for it drops. Loads and load-done pulses aimed at a ready buffer are ignored.
- R6: A read of address 3 returns the byte at the read pointer of the current transmit buffer. The read pointer advances only on a read of address 3 while that buffer is ready.
- R7: The current transmit buffer starts as buffer 1 and alternates. A command write that sets the bit of the current, ready buffer releases it, makes the other buffer current and resets the read pointer to 0. A release bit for the non-current buffer is ignored.
- R8: While the current transmit buffer is not ready, address 3 reads 0x00 and a read there does not move the read pointer.
- R9: A command write with bit 7 or bit 6 set is ignored in full.
- R10: Status bits 7:3 read 0. Address 2 and all other addresses read 0, and writes to them have no effect.
- R11: Byte pointers wrap from DEPTH-1 to 0, so write DEPTH+k lands on byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | CPU register address |
| regWrEn | input | 1 | CPU write strobe |
| regWrData | input | 8 | CPU write data |
| regRdEn | input | 1 | CPU read strobe (advances the data-port pointer) |
| regRdData | output | 8 | CPU read data for `regAddr`, combinational |
| swRxReady | output | 1 | Receive buffer holds a frame for the switch |
| swRxAddr | input | PTR_W | Switch read address into the receive buffer |
| swRxData | output | 8 | Receive buffer byte at `swRxAddr` |
| swRxDone | input | 1 | Switch has consumed the receive frame |
| swTxFree | output | 2 | Per transmit buffer: free for loading |
| swTxSel | input | 1 | Transmit buffer selected for load |
| swTxWrEn | input | 1 | Transmit load write enable |
| swTxAddr | input | PTR_W | Transmit load byte address |
| swTxWrData | input | 8 | Transmit load byte |
| swTxLoadDone | input | 1 | Selected transmit buffer is fully loaded |

## Verification
On every cycle, the assertions check the ownership handshakes: the receive buffer handing over and returning, the buffer staying with the switch until done, the load-done marking a buffer busy, a released buffer becoming free when the current buffer flips, reserved command writes leaving all flags stable, and zero reads from an empty data port or from reserved status bits. Only the bench's scenarios show the byte content, ordering and pointer behaviour. That includes the ping-pong drain order across several frames, ignored writes keeping old bytes, a load into a ready buffer not overwriting it, and the pointer wrapping past the buffer end. These are checked against a behavioural model compared every clock.

// File: rtl/mbxPkg.sv
package mbxPkg;
  localparam int NUM_TX = 2;
  localparam logic [2:0] ADDR_FRAME = 3'd3;
  localparam logic [2:0] ADDR_CMD   = 3'd4;

  typedef struct packed {
    logic rxWrEn;   // store CPU byte into receive buffer
    logic txLoadEn; // store switch byte into selected transmit buffer
    logic txRdBuf;  // transmit buffer presented on the data port
  } mbxStrobes_t;
endpackage

// File: rtl/mbxControl.sv
module mbxControl
  import mbxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             regRdEn,
  output logic [7:0]       regRdData,
  input  logic [7:0]       txByte,
  input  logic             swRxDone,
  input  logic             swTxSel,
  input  logic             swTxWrEn,
  input  logic             swTxLoadDone,
  output logic             rxCpuOwned,
  output logic [NUM_TX-1:0] txFull,
  output logic             curBuf,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output mbxStrobes_t      strobes
);
  logic dataWr, dataRd, cmdWr, rxHand, rxBack, relBit, txRelease;
  logic [NUM_TX-1:0] loadSet;
  logic unusedCmdBits;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign unusedCmdBits = ^regWrData[5:3];

  always_comb begin
    dataWr    = regWrEn && (regAddr == ADDR_FRAME);
    dataRd    = regRdEn && (regAddr == ADDR_FRAME);
    cmdWr     = regWrEn && (regAddr == ADDR_CMD) && (regWrData[7:6] == 2'b00);
    rxHand    = cmdWr && regWrData[0] && rxCpuOwned;
    rxBack    = swRxDone && !rxCpuOwned;
    relBit    = curBuf ? regWrData[2] : regWrData[1];
    txRelease = cmdWr && relBit && txFull[curBuf];
    strobes.rxWrEn   = dataWr && rxCpuOwned;
    strobes.txLoadEn = swTxWrEn && !txFull[swTxSel];
    strobes.txRdBuf  = curBuf;
  end

  for (genvar i = 0; i < NUM_TX; i++) begin : gLoad
    assign loadSet[i] = swTxLoadDone && (swTxSel == 1'(i)) && !txFull[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCpuOwned <= 1'b1;
      txFull     <= '0;
      curBuf     <= 1'b0;
      wrPtr      <= '0;
      rdPtr      <= '0;
    end else begin
      if (rxHand) rxCpuOwned <= 1'b0;
      else if (rxBack) rxCpuOwned <= 1'b1;

      if (rxHand || rxBack) wrPtr <= '0;
      else if (strobes.rxWrEn) wrPtr <= stepPtr(wrPtr);

      if (txRelease) begin
        rdPtr  <= '0;
        curBuf <= ~curBuf;
      end else if (dataRd && txFull[curBuf]) begin
        rdPtr <= stepPtr(rdPtr);
      end

      for (int i = 0; i < NUM_TX; i++) begin
        if (loadSet[i]) txFull[i] <= 1'b1;
        else if (txRelease && (curBuf == 1'(i))) txFull[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_FRAME: regRdData = txFull[curBuf] ? txByte : 8'h00;
      ADDR_CMD:   regRdData = {5'b0, txFull[1], txFull[0], rxCpuOwned};
      default:    regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/mbxDatapath.sv
module mbxDatapath
  import mbxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  mbxStrobes_t      strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [7:0]       regWrData,
  input  logic [PTR_W-1:0] swRxAddr,
  output logic [7:0]       swRxData,
  input  logic             swTxSel,
  input  logic [PTR_W-1:0] swTxAddr,
  input  logic [7:0]       swTxWrData,
  output logic [7:0]       txByte
);
  logic [7:0] rxMem [DEPTH];
  logic [7:0] bufOut [NUM_TX];

  always_ff @(posedge clk) begin
    if (strobes.rxWrEn) rxMem[wrPtr] <= regWrData;
  end
  assign swRxData = rxMem[swRxAddr];

  for (genvar i = 0; i < NUM_TX; i++) begin : gTxBuf
    logic [7:0] bufMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobes.txLoadEn && (swTxSel == 1'(i))) bufMem[swTxAddr] <= swTxWrData;
    end
    assign bufOut[i] = bufMem[rdPtr];
  end

  assign txByte = bufOut[strobes.txRdBuf];
endmodule

// File: rtl/ctrlFrameMailbox.sv
module ctrlFrameMailbox
  import mbxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             regRdEn,
  output logic [7:0]       regRdData,
  output logic             swRxReady,
  input  logic [PTR_W-1:0] swRxAddr,
  output logic [7:0]       swRxData,
  input  logic             swRxDone,
  output logic [1:0]       swTxFree,
  input  logic             swTxSel,
  input  logic             swTxWrEn,
  input  logic [PTR_W-1:0] swTxAddr,
  input  logic [7:0]       swTxWrData,
  input  logic             swTxLoadDone
);
  mbxStrobes_t strobes;
  logic rxCpuOwned, curBuf;
  logic [NUM_TX-1:0] txFull;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [7:0] txByte;

  mbxControl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .txByte(txByte), .swRxDone(swRxDone), .swTxSel(swTxSel),
    .swTxWrEn(swTxWrEn), .swTxLoadDone(swTxLoadDone),
    .rxCpuOwned(rxCpuOwned), .txFull(txFull), .curBuf(curBuf),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .strobes(strobes)
  );

  mbxDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .regWrData(regWrData), .swRxAddr(swRxAddr), .swRxData(swRxData),
    .swTxSel(swTxSel), .swTxAddr(swTxAddr), .swTxWrData(swTxWrData),
    .txByte(txByte)
  );

  assign swRxReady = ~rxCpuOwned;
  assign swTxFree  = ~txFull;
endmodule

// File: rtl/mbxChecker.sv
module mbxChecker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       swRxReady,
  input logic       swRxDone,
  input logic [1:0] swTxFree,
  input logic       swTxSel,
  input logic       swTxLoadDone,
  input logic       curBuf
);
  assert_handover_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd4 && regWrData[7:6] == 2'b00 && regWrData[0] && !swRxReady)
      |=> swRxReady);

  assert_return_R3: assert property (@(posedge clk) disable iff (!rstN)
    (swRxReady && swRxDone) |=> !swRxReady);

  assert_switch_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swRxReady && !swRxDone) |=> swRxReady);

  assert_load_marks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (swTxLoadDone && swTxFree[swTxSel]) |=> !swTxFree[$past(swTxSel)]);

  assert_flip_frees_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curBuf != $past(curBuf)) |-> swTxFree[$past(curBuf)]);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd3 && swTxFree[curBuf]) |-> regRdData == 8'h00);

  assert_reserved_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd4 && regWrData[7:6] != 2'b00 && !swRxDone && !swTxLoadDone)
      |=> ($stable(swRxReady) && $stable(swTxFree) && $stable(curBuf)));

  assert_status_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4) |-> regRdData[7:3] == 5'b0);
endmodule

bind ctrlFrameMailbox mbxChecker chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .swRxReady(swRxReady),
  .swRxDone(swRxDone), .swTxFree(swTxFree), .swTxSel(swTxSel),
  .swTxLoadDone(swTxLoadDone), .curBuf(curBuf)
);

// File: tb/ctrlFrameMailbox_test.sv
`timescale 1ns/1ps
module ctrlFrameMailbox_test;
  localparam int DEPTH = 64;
  localparam int PTR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic swRxReady, swRxDone = 1'b0;
  logic [PTR_W-1:0] swRxAddr = '0, swTxAddr = '0;
  logic [7:0] swRxData, swTxWrData = '0;
  logic [1:0] swTxFree;
  logic swTxSel = 1'b0, swTxWrEn = 1'b0, swTxLoadDone = 1'b0;

  int checks = 0, errors = 0;
  string curReq = "R1";
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  ctrlFrameMailbox #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .swRxReady(swRxReady), .swRxAddr(swRxAddr), .swRxData(swRxData),
    .swRxDone(swRxDone), .swTxFree(swTxFree), .swTxSel(swTxSel),
    .swTxWrEn(swTxWrEn), .swTxAddr(swTxAddr), .swTxWrData(swTxWrData),
    .swTxLoadDone(swTxLoadDone)
  );

  // Behavioural reference model
  bit mRxCpu, mCur;
  bit mFull [2];
  int mWrPtr, mRdPtr;
  int mRx [DEPTH];
  bit mRxV [DEPTH];
  int mTx [2][DEPTH];
  bit mTxV [2][DEPTH];

  always @(posedge clk) begin
    if (!rstN) begin
      mRxCpu = 1; mCur = 0; mFull[0] = 0; mFull[1] = 0; mWrPtr = 0; mRdPtr = 0;
    end else begin
      bit oldFull [2];
      bit oldRxCpu, oldCur;
      oldFull = mFull; oldRxCpu = mRxCpu; oldCur = mCur;
      if (regWrEn && regAddr == 3 && oldRxCpu) begin
        mRx[mWrPtr] = int'(regWrData); mRxV[mWrPtr] = 1;
        mWrPtr = (mWrPtr + 1) % DEPTH;
      end
      if (regRdEn && regAddr == 3 && oldFull[oldCur]) mRdPtr = (mRdPtr + 1) % DEPTH;
      if (regWrEn && regAddr == 4 && regWrData[7:6] == 0) begin
        if (regWrData[0] && oldRxCpu) begin mRxCpu = 0; mWrPtr = 0; end
        if (regWrData[int'(oldCur) + 1] && oldFull[oldCur]) begin
          mFull[oldCur] = 0; mCur = !oldCur; mRdPtr = 0;
        end
      end
      if (swRxDone && !oldRxCpu) begin mRxCpu = 1; mWrPtr = 0; end
      if (swTxWrEn && !oldFull[swTxSel]) begin
        mTx[swTxSel][swTxAddr] = int'(swTxWrData); mTxV[swTxSel][swTxAddr] = 1;
      end
      if (swTxLoadDone && !oldFull[swTxSel]) mFull[swTxSel] = 1;
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [7:0] expRd;
    bit known = 1;
    if (regAddr == 3) begin
      if (mFull[mCur]) begin
        known = mTxV[mCur][mRdPtr];
        expRd = 8'(mTx[mCur][mRdPtr]);
      end else expRd = 8'h00;
    end else if (regAddr == 4) expRd = {5'b0, mFull[1], mFull[0], mRxCpu};
    else expRd = 8'h00;
    if (known) check(curReq, "model regRdData", regRdData, expRd);
    check(curReq, "model swRxReady", {7'b0, swRxReady}, {7'b0, !mRxCpu});
    check(curReq, "model swTxFree", {6'b0, swTxFree}, {6'b0, !mFull[1], !mFull[0]});
    if (mRxV[swRxAddr]) check(curReq, "model swRxData", swRxData, 8'(mRx[swRxAddr]));
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  task automatic cpuWrite(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1; tick(); regWrEn = 0;
  endtask

  task automatic cpuRead(output logic [7:0] d);
    regAddr = 3; regRdEn = 1; #1 d = regRdData; tick(); regRdEn = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1 d = regRdData;
  endtask

  task automatic swLoad(bit sel, logic [7:0] base, int n);
    for (int i = 0; i < n; i++) begin
      swTxSel = sel; swTxAddr = PTR_W'(i); swTxWrData = base + 8'(i); swTxWrEn = 1; tick();
    end
    swTxWrEn = 0; swTxLoadDone = 1; tick(); swTxLoadDone = 0;
  endtask

  task automatic rxDonePulse();
    swRxDone = 1; tick(); swRxDone = 0;
  endtask

  task automatic peekRx(int a, output logic [7:0] d);
    swRxAddr = PTR_W'(a); #1 d = swRxData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    // R1: reset state
    curReq = "R1";
    peek(4, rd); check("R1", "status after reset", rd, 8'h01);
    peek(3, rd); check("R1", "data port after reset", rd, 8'h00);

    // R2, R9, R3, R4: receive path
    curReq = "R2";
    for (int i = 0; i < 16; i++) cpuWrite(3, 8'h10 + 8'(i));
    curReq = "R9";
    cpuWrite(4, 8'hC1);
    peek(4, rd); check("R9", "reserved cmd ignored", rd, 8'h01);
    curReq = "R3";
    cpuWrite(4, 8'h01);
    check("R3", "swRxReady after handover", {7'b0, swRxReady}, 8'h01);
    peek(4, rd); check("R3", "status after handover", rd, 8'h00);
    for (int i = 0; i < 16; i++) begin
      peekRx(i, rd); check("R2", "rx byte", rd, 8'h10 + 8'(i));
    end
    curReq = "R4";
    cpuWrite(3, 8'hEE);
    peekRx(0, rd); check("R4", "write while switch owns", rd, 8'h10);
    curReq = "R3";
    rxDonePulse();
    peek(4, rd); check("R3", "status after return", rd, 8'h01);
    cpuWrite(3, 8'h5A);
    cpuWrite(4, 8'h01);
    peekRx(0, rd); check("R3", "pointer restarted", rd, 8'h5A);
    peekRx(1, rd); check("R3", "byte 1 kept", rd, 8'h11);
    rxDonePulse();

    // R5, R6, R7, R8: transmit path
    curReq = "R5";
    swLoad(1, 8'h80, 8);
    peek(4, rd); check("R5", "buffer2 ready", rd, 8'h05);
    curReq = "R8";
    cpuRead(rd); check("R8", "read with buffer1 empty", rd, 8'h00);
    curReq = "R5";
    swLoad(0, 8'h40, 8);
    peek(4, rd); check("R5", "both ready", rd, 8'h07);
    swTxSel = 0; swTxAddr = 0; swTxWrData = 8'hFF; swTxWrEn = 1; tick(); swTxWrEn = 0;
    curReq = "R6";
    for (int i = 0; i < 8; i++) begin
      cpuRead(rd); check("R6", "buffer1 byte", rd, 8'h40 + 8'(i));
    end
    curReq = "R7";
    cpuWrite(4, 8'h04);
    peek(4, rd); check("R7", "non-current release ignored", rd, 8'h07);
    cpuWrite(4, 8'h02);
    peek(4, rd); check("R7", "buffer1 released", rd, 8'h05);
    cpuRead(rd); check("R7", "buffer2 byte0", rd, 8'h80);
    cpuRead(rd); check("R7", "buffer2 byte1", rd, 8'h81);
    cpuWrite(4, 8'h04);
    peek(4, rd); check("R7", "buffer2 released", rd, 8'h01);
    curReq = "R8";
    cpuRead(rd); check("R8", "read with none ready", rd, 8'h00);
    curReq = "R7";
    swLoad(1, 8'hA0, 4);
    peek(3, rd); check("R7", "buffer1 current again", rd, 8'h00);
    swLoad(0, 8'hC0, 4);
    cpuRead(rd); check("R7", "buffer1 read first", rd, 8'hC0);
    cpuWrite(4, 8'h02);
    cpuRead(rd); check("R7", "then buffer2", rd, 8'hA0);
    cpuWrite(4, 8'h04);

    // R10: other addresses
    curReq = "R10";
    cpuWrite(2, 8'h77);
    peek(2, rd); check("R10", "address 2 reads 0", rd, 8'h00);
    peek(4, rd); check("R10", "status unchanged", rd, 8'h01);

    // R11: pointer wrap
    curReq = "R11";
    for (int i = 0; i < DEPTH + 2; i++) cpuWrite(3, 8'(i));
    cpuWrite(4, 8'h01);
    peekRx(0, rd); check("R11", "wrapped byte 0", rd, 8'(DEPTH));
    peekRx(1, rd); check("R11", "wrapped byte 1", rd, 8'(DEPTH + 1));
    peekRx(2, rd); check("R11", "byte 2 kept", rd, 8'h02);
    rxDonePulse();
    tick();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule